// File: doc/BRIEF.md
# Dual-Mode PWM Cycle Timer Status

This block runs four 16-bit free-running counters, channels A to D, and keeps a status byte about them. Each channel has its own cycle register. A single mode input selects how all four counters run. In normal PWM mode each counter only counts up and wraps to zero. In complementary PWM mode each counter moves in a triangle: up to its cycle value, then down to zero, then up again.

The status byte holds one count-direction bit and one cycle compare-match flag per channel. The condition that sets a flag depends on the mode. In normal mode a flag is set when the counter equals its cycle value. In complementary mode a flag is set when the counter sits at zero while it is counting down.

Software clears a flag in two steps. It first reads the flag while the flag is 1, then writes 0 to that bit. A second register holds one interrupt enable bit per channel. The interrupt request is the OR of the flags whose enable bits are set.

Top module: `pwm_cycle_status`

## Requirements
- R1: After synchronous reset the status byte reads 0x00, the enable register reads 0x00 and `irq` is low. Every cycle register resets to 0xFFFF, the mode is normal and every counter is at 0 counting up.
- R2: In normal mode a counter adds one per clock. On the clock after its value equals or exceeds its cycle register, it goes to 0. Its direction bit stays 0 (up).
- R3: In normal mode a channel's flag is set on the clock edge that ends the cycle in which the counter equals its cycle register. The flag reads 1 from the next cycle on.
- R4: In complementary mode a counting-up counter that has reached or passed its cycle value moves to value minus one and turns to down. A counting-down counter at 0 moves to 1 and turns to up. The direction bit (1 = down) changes on the same edge as the reversal.
- R5: In complementary mode a channel's flag is set on the edge that ends a cycle in which that counter is at 0x0000 and counting down. A count equal to the cycle value does not set the flag in this mode.
- R6: Status byte at bus address 0. Bits 3..0 are the compare flags of channels D, C, B and A. Bits 7..4 are the direction bits of channels D, C, B and A, so bit 5 is channel B and bit 4 is channel A.
- R7: A flag that was read as 1 (bus read of address 0) is cleared when 0 is later written to its bit at address 0. The first read after a flag is cleared arms nothing, because the flag then reads 0.
- R8: Writing 0 to a flag that has not been read as 1 leaves it set. Writing 1 to a flag bit never changes it, and the arming from the earlier read stays in place.
- R9: When a set condition and a valid clearing write fall in the same cycle, the flag stays 1 and must be read again before it can be cleared.
- R10: Writing bus address 1 loads the enable bits from `bus_wdata[3:0]` (bit 0 is channel A). Reading address 1 returns them in bits 3..0, with zeros in bits 7..4. `irq` is high exactly while some flag and its enable bit are both 1.
- R11: A change of `comp_mode` takes effect on the next clock edge. On that edge every counter restarts at 0 counting up. The flags raised in that cycle still follow the previous mode.
- R12: When `cyc_we` is high, the cycle register selected by `cyc_sel` (0 = A … 3 = D) loads `cyc_wdata` on the next edge. The other cycle registers keep their values.
- R13: In complementary mode a channel whose cycle value is 0 holds its counter at 0 counting up and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| comp_mode | input | 1 | 0 = normal PWM, 1 = complementary PWM |
| cyc_we | input | 1 | Cycle register write strobe |
| cyc_sel | input | 2 | Channel selected by the cycle register write |
| cyc_wdata | input | 16 | Cycle register write value |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = status byte, 1 = interrupt enables |
| bus_wdata | input | 4 | Write data; one bit per channel |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The counters have no port of their own, so any error in a count, a wrap point or a reversal shows up only through the status byte. A direction bit flips on the wrong cycle, or a compare flag rises early or late. The bench reads the status byte every cycle and compares it with a model, so such an error is reported in the first cycle it reaches a flag or direction bit: at the latest one counter period after the fault. An error in the arming state stays hidden until the next write of 0. At that write a flag either clears when it should have held, or holds when it should have cleared. The bench therefore follows every clearing write with reads, and the mismatch is reported in the cycle right after the write.

// File: rtl/cts_pkg.sv
package cts_pkg;

    localparam int NUM_CH = 4;
    localparam int SEL_W  = $clog2(NUM_CH);
    localparam int STAT_W = 2 * NUM_CH;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_COMP   = 1'b1
    } pwm_mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    // Status byte: direction bits above compare flags, channel A in the low bit of each half
    typedef struct packed {
        logic [NUM_CH-1:0] dir;
        logic [NUM_CH-1:0] cmf;
    } status_t;

    localparam logic REG_STATUS = 1'b0;
    localparam logic REG_IRQ_EN = 1'b1;

    // Flags that a write would clear: armed by an earlier read and written as zero
    function automatic logic [NUM_CH-1:0] clear_mask(
        input logic [NUM_CH-1:0] armed,
        input logic [NUM_CH-1:0] wbits,
        input logic              hit
    );
        return hit ? (armed & ~wbits) : '0;
    endfunction

endpackage

// File: rtl/cts_counter.sv
module cts_counter
    import cts_pkg::*;
#(
    parameter int CNT_W = 16
)
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_comp,
    input  logic             restart,
    input  logic [CNT_W-1:0] cyc,
    output logic             down_o,
    output logic             match_o
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        cnt_dir_e         dir;
    } ctr_t;

    ctr_t cur_q;
    ctr_t nxt;
    logic at_top;
    logic at_zero;

    assign at_top  = (cur_q.cnt >= cyc);
    assign at_zero = (cur_q.cnt == CNT_ZERO);

    always_comb begin
        nxt = cur_q;
        if (restart) begin
            nxt.cnt = CNT_ZERO;
            nxt.dir = DIR_UP;
        end else if (!mode_comp) begin
            nxt.dir = DIR_UP;
            nxt.cnt = at_top ? CNT_ZERO : cur_q.cnt + CNT_ONE;
        end else if (cyc == CNT_ZERO) begin
            nxt.cnt = CNT_ZERO;
            nxt.dir = DIR_UP;
        end else if (cur_q.dir == DIR_UP) begin
            if (at_top) begin
                nxt.dir = DIR_DOWN;
                nxt.cnt = cur_q.cnt - CNT_ONE;
            end else begin
                nxt.cnt = cur_q.cnt + CNT_ONE;
            end
        end else begin
            if (at_zero) begin
                nxt.dir = DIR_UP;
                nxt.cnt = CNT_ONE;
            end else begin
                nxt.cnt = cur_q.cnt - CNT_ONE;
            end
        end
    end

    always_comb begin
        if (mode_comp) begin
            match_o = (cur_q.dir == DIR_DOWN) && at_zero;
        end else begin
            match_o = (cur_q.cnt == cyc);
        end
    end

    assign down_o = (cur_q.dir == DIR_DOWN);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.cnt <= CNT_ZERO;
            cur_q.dir <= DIR_UP;
        end else begin
            cur_q <= nxt;
        end
    end

    // R2: a normal-mode counter that matches its cycle value goes to zero next
    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (!restart && !mode_comp && cur_q.cnt == cyc) |=> (cur_q.cnt == CNT_ZERO));

    // R2: normal mode leaves the counter counting up
    p_dir_normal_r2: assert property (@(posedge clk) disable iff (rst)
        !mode_comp |=> (cur_q.dir == DIR_UP));

    // R4: on the way up below the cycle value the counter steps by one
    p_rise_r4: assert property (@(posedge clk) disable iff (rst)
        (!restart && mode_comp && cur_q.dir == DIR_UP && cur_q.cnt < cyc)
        |=> (cur_q.cnt == $past(cur_q.cnt) + CNT_ONE));

    // R4: a down-count at zero turns back up
    p_turn_r4: assert property (@(posedge clk) disable iff (rst)
        (!restart && mode_comp && cyc != CNT_ZERO && cur_q.dir == DIR_DOWN && at_zero)
        |=> (cur_q.dir == DIR_UP && cur_q.cnt == CNT_ONE));

    // R11: a mode change restarts the counter at zero counting up
    p_restart_r11: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cur_q.cnt == CNT_ZERO && cur_q.dir == DIR_UP));

endmodule

// File: rtl/cts_regs.sv
module cts_regs
    import cts_pkg::*;
#(
    parameter int               CNT_W   = 16,
    parameter logic [CNT_W-1:0] CYC_RST = '1
)
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         comp_mode_i,
    input  logic                         cyc_we_i,
    input  logic [SEL_W-1:0]             cyc_sel_i,
    input  logic [CNT_W-1:0]             cyc_data_i,
    input  logic                         ie_we_i,
    input  logic [NUM_CH-1:0]            ie_data_i,
    output logic [NUM_CH-1:0][CNT_W-1:0] cyc_o,
    output logic [NUM_CH-1:0]            ie_o,
    output logic                         mode_comp_o,
    output logic                         restart_o
);

    logic [CNT_W-1:0] cyc_q [NUM_CH];
    logic [NUM_CH-1:0] ie_q;
    pwm_mode_e         mode_q;
    pwm_mode_e         mode_req;

    assign mode_req = comp_mode_i ? MODE_COMP : MODE_NORMAL;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cyc
        always_ff @(posedge clk) begin
            if (rst) begin
                cyc_q[ch] <= CYC_RST;
            end else if (cyc_we_i && cyc_sel_i == SEL_W'(ch)) begin
                cyc_q[ch] <= cyc_data_i;
            end
        end
        assign cyc_o[ch] = cyc_q[ch];

        // R12: a selected write lands in this channel's cycle register
        p_cyc_load_r12: assert property (@(posedge clk) disable iff (rst)
            (cyc_we_i && cyc_sel_i == SEL_W'(ch)) |=> (cyc_o[ch] == $past(cyc_data_i)));

        // R12: an unselected channel keeps its cycle value
        p_cyc_hold_r12: assert property (@(posedge clk) disable iff (rst)
            !(cyc_we_i && cyc_sel_i == SEL_W'(ch)) |=> $stable(cyc_o[ch]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q   <= '0;
            mode_q <= MODE_NORMAL;
        end else begin
            mode_q <= mode_req;
            if (ie_we_i) begin
                ie_q <= ie_data_i;
            end
        end
    end

    assign ie_o        = ie_q;
    assign mode_comp_o = (mode_q == MODE_COMP);
    assign restart_o   = (mode_req != mode_q);

    // R10: the enable register takes the written value
    p_ie_load_r10: assert property (@(posedge clk) disable iff (rst)
        ie_we_i |=> (ie_o == $past(ie_data_i)));

    // R11: the mode follows the input one edge later
    p_mode_follow_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (mode_comp_o == $past(comp_mode_i)));

endmodule

// File: rtl/cts_flags.sv
module cts_flags
    import cts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] set_i,
    input  logic              rd_hit_i,
    input  logic              wr_hit_i,
    input  logic [NUM_CH-1:0] wbits_i,
    output logic [NUM_CH-1:0] flag_o
);

    logic [NUM_CH-1:0] flag_q;
    logic [NUM_CH-1:0] arm_q;
    logic [NUM_CH-1:0] clr;
    logic [NUM_CH-1:0] flag_d;
    logic [NUM_CH-1:0] arm_d;

    always_comb begin
        clr    = clear_mask(arm_q, wbits_i, wr_hit_i);
        flag_d = set_i | (flag_q & ~clr);
        arm_d  = flag_d & (rd_hit_i ? flag_q : arm_q) & ~clr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            arm_q  <= '0;
        end else begin
            flag_q <= flag_d;
            arm_q  <= arm_d;
        end
    end

    assign flag_o = flag_q;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        // R3 R5 R9: a set condition always leaves the flag at one
        p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
            set_i[ch] |=> flag_q[ch]);

        // R8: an unarmed flag survives any write
        p_hold_unarmed_r8: assert property (@(posedge clk) disable iff (rst)
            (flag_q[ch] && !arm_q[ch]) |=> flag_q[ch]);

        // R7: a flag only falls after an armed zero write
        p_fall_armed_r7: assert property (@(posedge clk) disable iff (rst)
            $fell(flag_q[ch]) |-> $past(wr_hit_i && arm_q[ch] && !wbits_i[ch]));

        // R7: arming never outlives its flag
        p_arm_needs_flag_r7: assert property (@(posedge clk) disable iff (rst)
            arm_q[ch] |-> flag_q[ch]);
    end

endmodule

// File: rtl/pwm_cycle_status.sv
module pwm_cycle_status
    import cts_pkg::*;
#(
    parameter int               CNT_W   = 16,
    parameter logic [CNT_W-1:0] CYC_RST = '1
)
(
    input  logic              clk,
    input  logic              rst,
    input  logic              comp_mode,
    input  logic              cyc_we,
    input  logic [SEL_W-1:0]  cyc_sel,
    input  logic [CNT_W-1:0]  cyc_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [NUM_CH-1:0] bus_wdata,
    output logic [STAT_W-1:0] bus_rdata,
    output logic              irq
);

    logic [NUM_CH-1:0][CNT_W-1:0] cyc_vec;
    logic [NUM_CH-1:0]            ie_vec;
    logic [NUM_CH-1:0]            dir_vec;
    logic [NUM_CH-1:0]            set_vec;
    logic [NUM_CH-1:0]            flag_vec;
    logic                         mode_comp_q;
    logic                         restart;
    logic                         stat_rd;
    logic                         stat_wr;
    logic                         ie_wr;
    status_t                      stat;

    assign stat_rd = bus_rd && (bus_addr == REG_STATUS);
    assign stat_wr = bus_wr && (bus_addr == REG_STATUS);
    assign ie_wr   = bus_wr && (bus_addr == REG_IRQ_EN);

    cts_regs #(
        .CNT_W   (CNT_W),
        .CYC_RST (CYC_RST)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .comp_mode_i (comp_mode),
        .cyc_we_i    (cyc_we),
        .cyc_sel_i   (cyc_sel),
        .cyc_data_i  (cyc_wdata),
        .ie_we_i     (ie_wr),
        .ie_data_i   (bus_wdata),
        .cyc_o       (cyc_vec),
        .ie_o        (ie_vec),
        .mode_comp_o (mode_comp_q),
        .restart_o   (restart)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        cts_counter #(
            .CNT_W (CNT_W)
        ) u_ctr (
            .clk       (clk),
            .rst       (rst),
            .mode_comp (mode_comp_q),
            .restart   (restart),
            .cyc       (cyc_vec[ch]),
            .down_o    (dir_vec[ch]),
            .match_o   (set_vec[ch])
        );
    end

    cts_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_i    (set_vec),
        .rd_hit_i (stat_rd),
        .wr_hit_i (stat_wr),
        .wbits_i  (bus_wdata),
        .flag_o   (flag_vec)
    );

    always_comb begin
        stat.dir = dir_vec;
        stat.cmf = flag_vec;
        if (bus_addr == REG_STATUS) begin
            bus_rdata = stat;
        end else begin
            bus_rdata = {{NUM_CH{1'b0}}, ie_vec};
        end
    end

    assign irq = |(flag_vec & ie_vec);

    // R10: no request without a raised flag
    p_irq_src_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag_vec != '0));

    // R10: with every enable cleared the request stays low
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (rst)
        (ie_vec == '0) |-> !irq);

    // R2: direction bits stay low while the registered mode is normal
    p_dir_low_r2: assert property (@(posedge clk) disable iff (rst)
        (!mode_comp_q && !$past(mode_comp_q)) |-> (dir_vec == '0));

endmodule

// File: tb/test_pwm_cycle_status.sv
`timescale 1ns/1ps
module test_pwm_cycle_status;
    import cts_pkg::*;

    localparam int CNT_W = 16;
    localparam int NCH   = NUM_CH;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              comp_mode = 1'b0;
    logic              cyc_we;
    logic [SEL_W-1:0]  cyc_sel;
    logic [CNT_W-1:0]  cyc_wdata;
    logic              bus_rd;
    logic              bus_wr;
    logic              bus_addr;
    logic [NCH-1:0]    bus_wdata;
    logic [STAT_W-1:0] bus_rdata;
    logic              irq;

    always #4 clk = ~clk;

    pwm_cycle_status i_pwm_cycle_status (
        .clk       (clk),
        .rst       (rst),
        .comp_mode (comp_mode),
        .cyc_we    (cyc_we),
        .cyc_sel   (cyc_sel),
        .cyc_wdata (cyc_wdata),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    string phase   = "R1";
    bit    done    = 0;

    int unsigned m_cnt [NCH];
    int unsigned m_cyc [NCH];
    bit m_dir  [NCH];
    bit m_flag [NCH];
    bit m_arm  [NCH];
    bit m_ie   [NCH];
    bit m_mode;

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_cnt[i] = 0; m_cyc[i] = 32'hFFFF; m_dir[i] = 0;
            m_flag[i] = 0; m_arm[i] = 0; m_ie[i] = 0;
        end
        m_mode = 0;
    endtask

    // One clock of the behaviour listed in the requirements
    task automatic model_step();
        bit rd_s    = bus_rd && (bus_addr == 1'b0);
        bit wr_s    = bus_wr && (bus_addr == 1'b0);
        bit restart = (comp_mode != m_mode);
        for (int i = 0; i < NCH; i++) begin
            bit set_e, clr, nf;
            int unsigned nc;
            bit nd;
            set_e = m_mode ? (m_dir[i] && m_cnt[i] == 0) : (m_cnt[i] == m_cyc[i]);
            nc = m_cnt[i]; nd = m_dir[i];
            if (restart) begin
                nc = 0; nd = 0;
            end else if (!m_mode) begin
                nd = 0; nc = (m_cnt[i] >= m_cyc[i]) ? 0 : m_cnt[i] + 1;
            end else if (m_cyc[i] == 0) begin
                nc = 0; nd = 0;
            end else if (!m_dir[i]) begin
                if (m_cnt[i] >= m_cyc[i]) begin nd = 1; nc = m_cnt[i] - 1; end
                else nc = m_cnt[i] + 1;
            end else begin
                if (m_cnt[i] == 0) begin nd = 0; nc = 1; end
                else nc = m_cnt[i] - 1;
            end
            clr = wr_s && m_arm[i] && !bus_wdata[i];
            nf  = set_e || (m_flag[i] && !clr);
            m_arm[i]  = nf && (rd_s ? m_flag[i] : m_arm[i]) && !clr;
            m_flag[i] = nf;
            m_cnt[i]  = nc;
            m_dir[i]  = nd;
        end
        if (cyc_we) m_cyc[cyc_sel] = cyc_wdata;
        if (bus_wr && bus_addr == 1'b1)
            for (int i = 0; i < NCH; i++) m_ie[i] = bus_wdata[i];
        m_mode = comp_mode;
    endtask

    always @(posedge clk) begin
        if (rst) model_reset();
        else     model_step();
    end

    function automatic logic [7:0] exp_rdata();
        logic [7:0] v = '0;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == 1'b0) begin
                v[i] = m_flag[i]; v[4+i] = m_dir[i];
            end else begin
                v[i] = m_ie[i];
            end
        end
        return v;
    endfunction

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int i = 0; i < NCH; i++) r |= m_flag[i] & m_ie[i];
        return r;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk(phase, "bus_rdata", 32'(bus_rdata), 32'(exp_rdata()));
        chk(phase, "irq", 32'(irq), 32'(exp_irq()));
    endtask

    task automatic idle();
        bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = '0;
        cyc_we = 0; cyc_sel = '0; cyc_wdata = '0;
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic bus_op(bit rd, bit wr, bit addr, logic [NCH-1:0] d);
        bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_wdata = d;
        tick();
        idle();
    endtask

    task automatic cyc_write(int ch, int unsigned val);
        cyc_we = 1; cyc_sel = SEL_W'(ch); cyc_wdata = CNT_W'(val);
        tick();
        idle();
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240));
        idle();
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset values of status, enables and irq
        phase = "R1";
        tick();
        bus_addr = 1; tick(); bus_addr = 0;
        tick();

        // R12: load distinct cycle values
        phase = "R12";
        cyc_write(0, 6); cyc_write(1, 9); cyc_write(2, 12); cyc_write(3, 15);

        // R2 R3 R6: normal counting, wrap and flag layout
        phase = "R2 R3 R6";
        run(60);

        // R8: writes without arming, then ones after arming
        phase = "R8";
        for (int i = 0; i < NCH; i++) cyc_write(i, 250);
        bus_op(0, 1, 0, 4'h0);
        run(3);
        bus_op(1, 0, 0, 4'h0);
        bus_op(0, 1, 0, 4'hF);
        run(3);

        // R7: armed zero write clears
        phase = "R7";
        bus_op(0, 1, 0, 4'h0);
        run(4);
        bus_op(1, 0, 0, 4'h0);
        bus_op(0, 1, 0, 4'h0);

        // R9: clearing writes swept against set events of a short cycle
        phase = "R9";
        cyc_write(0, 3);
        run(10);
        for (int k = 0; k < 4; k++) begin
            bus_op(1, 0, 0, 4'h0);
            run(k);
            bus_op(0, 1, 0, 4'h0);
            run(3);
        end

        // R10: enables and interrupt request
        phase = "R10";
        bus_op(0, 1, 1, 4'b0101);
        run(12);
        bus_addr = 1; tick(); bus_addr = 0;
        bus_op(0, 1, 1, 4'hF);
        run(6);
        bus_op(1, 0, 0, 4'h0);
        bus_op(0, 1, 0, 4'h0);
        run(4);
        bus_op(0, 1, 1, 4'h0);
        run(2);

        // R11 R4 R5: switch to complementary mode
        phase = "R11 R4 R5";
        comp_mode = 1;
        cyc_write(0, 4); cyc_write(1, 5); cyc_write(2, 6); cyc_write(3, 7);
        run(80);

        // R13: zero cycle value in complementary mode
        phase = "R13";
        cyc_write(0, 0);
        bus_op(1, 0, 0, 4'h0);
        bus_op(0, 1, 0, 4'h0);
        run(24);

        // R11: back to normal mode
        phase = "R11";
        comp_mode = 0;
        run(30);

        // Mixed random traffic
        phase = "R4 R5 R7 R8 R9 R10 R12";
        for (int it = 0; it < 3000; it++) begin
            int unsigned r = $urandom_range(0, 99);
            idle();
            if (r < 20) begin
                bus_rd = 1;
            end else if (r < 40) begin
                bus_wr = 1; bus_wdata = NCH'($urandom_range(0, 15));
            end else if (r < 45) begin
                bus_wr = 1; bus_addr = 1; bus_wdata = NCH'($urandom_range(0, 15));
            end else if (r < 50) begin
                cyc_we = 1; cyc_sel = SEL_W'($urandom_range(0, NCH-1));
                cyc_wdata = CNT_W'($urandom_range(0, 20));
            end else if (r < 51) begin
                comp_mode = ~comp_mode;
            end else if (r < 60) begin
                bus_addr = 1;
            end
            tick();
        end
        idle();

        done = 1;
        summary();
        $finish;
    end

endmodule